// File: doc/BRIEF.md
# Toggle-Bit Completion Polling Controller

This block runs on the host side of a parallel flash device. It decides when a program or erase operation that is already under way inside the device has finished. It does this by issuing status reads through a simple request/acknowledge bus port. It then compares the toggle bit of two reads made one after the other. A toggle bit that holds its value means the operation has ended. A toggle bit that keeps flipping means the device is still busy.

The device also reports a timeout flag. When the timeout flag is seen high, the controller does not fail at once. It first makes one more pair of reads, because the toggle bit may have stopped in the same moment the flag rose. Only a toggle bit that is still flipping in that extra pair counts as a failure. On any failure the controller writes the reset command to the device, so that the device returns to array reads. After that write it reports done with a fail result. A limit on the number of read pairs guards against a device that never settles.

Software can drop a poll at any time through an abort input, for example to run other tasks. The next start then begins from the first read pair with all history cleared. The electrical timing of the bus is left to an external bus master. That master must leave its read strobe inactive in the idle cycle between two requests.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After an accepted start, the block issues status reads (`bus_we`=0) at the address held on `op_addr` at the start. Reads come in pairs, and `bus_req` is low for at least one cycle after every acknowledged transfer.
- R2: If bit 6 (toggle bit) of the first read of a pair equals bit 6 of the second read, the block sets `done`=1 and `pass`=1. It issues no write.
- R3: If bit 6 differs within a pair and bit 5 (timeout flag) of the second read is 0, the block issues a new pair of reads.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 1, the block makes one more pair of reads (the recheck pair). If bit 6 is equal in the recheck pair, the result is `pass`=1.
- R5: If bit 6 still differs in the recheck pair, the block writes 0xF0 once to the operation address. `done` then rises with `pass`=0 in the cycle after that write is acknowledged.
- R6: The block makes at most `MAX_PAIRS` read pairs. If the last allowed pair still toggles and no pass was found, it fails with the same reset write as in R5. That is exactly 2*`MAX_PAIRS` reads.
- R7: `done` and `pass` hold their values until the next start. `done` falls once a new start is accepted, and a start that arrives while a poll is running is ignored.
- R8: An abort while busy returns the block to idle. `bus_req` is low in the next cycle and `done` stays low. The next start begins a fresh poll, with the pair count and the recheck state cleared.
- R9: After reset, `bus_req`, `done` and `pass` are 0.
- R10: While `bus_req` is high and not yet acknowledged, `bus_we`, `bus_addr` and `bus_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a poll |
| abort | input | 1 | Drops a running poll |
| op_addr | input | ADDR_W | Address used for status reads and the reset write |
| bus_req | output | 1 | Transfer request to the bus master |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Transfer complete; read data valid in the same cycle |
| bus_rdata | input | DATA_W | Read data |
| done | output | 1 | The poll has ended |
| pass | output | 1 | Result: 1 = completed, 0 = failed |

## Verification
Some internal faults show up at the ports within one poll. A lost or stale first sample turns a quiet pair into a false toggle, or the reverse, and the read count changes at once. A recheck flag that is stuck, or that survives an abort, makes the block fail two reads early or skip the extra pair. A wrong pair count moves the forced failure away from read 2*`MAX_PAIRS`. A missing idle gap or a dropped reset write is caught by the bus monitor in the cycle after it happens.

// File: rtl/toggle_poll_pkg.sv
// Package: shared types and the decision rule of the toggle-bit polling controller.
// Assumes: the caller evaluates a decision only once a full read pair has been taken.
package toggle_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_DECIDE,
        ST_CMD_RESET,
        ST_DONE
    } poll_state_t;

    typedef enum logic [1:0] {
        DEC_PASS,
        DEC_AGAIN,
        DEC_RECHECK,
        DEC_FAIL
    } decision_t;

    // Outcome of one completed read pair.
    function automatic decision_t decide(input logic toggled,
                                         input logic timeout_seen,
                                         input logic rechecking,
                                         input logic at_limit);
        decision_t d;
        if (!toggled)
            d = DEC_PASS;
        else if (rechecking || at_limit)
            d = DEC_FAIL;
        else if (timeout_seen)
            d = DEC_RECHECK;
        else
            d = DEC_AGAIN;
        return d;
    endfunction

endpackage

// File: rtl/tp_bus_port.sv
// Module: request side of a simple req/ack bus. It launches one transfer whenever
// the controller wants one, holds the fields steady until ack, and leaves one idle cycle
// after every transfer so the bus master can deassert its read strobe.
// Assumes: ack is a single-cycle pulse, and read data is valid alongside it.
module tp_bus_port #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want,
    input  logic              drop,
    input  logic              want_we,
    input  logic [ADDR_W-1:0] want_addr,
    input  logic [DATA_W-1:0] want_wdata,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              xfer_done
);

    // Request launch, hold and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (drop || !want) begin
            bus_req <= 1'b0;
        end else if (!bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= want_we;
            bus_addr  <= want_addr;
            bus_wdata <= want_wdata;
        end else if (bus_ack) begin
            bus_req <= 1'b0;
        end
    end

    // Transfer completion strobe for the controller.
    always_comb xfer_done = bus_req && bus_ack;

    // R10
    fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && want && !drop) |=>
            (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    // R1
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req);

endmodule

// File: rtl/tp_sample_cmp.sv
// Module: holds the toggle bit of the first and second read of a pair, plus the
// timeout flag of the second read, and reports whether the toggle bit moved.
// Assumes: the two captures of one pair never happen in the same cycle.
module tp_sample_cmp #(
    parameter int DATA_W  = 8,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_first,
    input  logic              cap_second,
    input  logic [DATA_W-1:0] rdata,
    output logic              toggled,
    output logic              timeout_hi
);

    logic first_bit;
    logic second_bit;

    // Sample capture per read of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_bit  <= 1'b0;
            second_bit <= 1'b0;
            timeout_hi <= 1'b0;
        end else if (cap_first) begin
            first_bit <= rdata[TOG_BIT];
        end else if (cap_second) begin
            second_bit <= rdata[TOG_BIT];
            timeout_hi <= rdata[TMO_BIT];
        end
    end

    // Toggle detection between the two samples.
    always_comb toggled = first_bit ^ second_bit;

    // R1
    one_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_first && cap_second));

endmodule

// File: rtl/tp_pair_count.sv
// Module: counts read pairs that ended in "poll again" and flags when the pair
// just finished is the last one allowed.
// Assumes: bump is never raised while at_limit is high.
module tp_pair_count #(
    parameter int MAX_PAIRS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);

    localparam int CW = $clog2(MAX_PAIRS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

    logic [CW-1:0] count;

    // Pair counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (bump)
            count <= count + 1'b1;
    end

    // Limit flag for the pair being evaluated.
    always_comb at_limit = (count >= LAST);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> !at_limit);

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);

endmodule

// File: rtl/toggle_poll_ctrl.sv
// Module: toggle-bit completion polling controller. It reads status in pairs until
// the toggle bit settles. After a timeout flag it makes exactly one more pair, and on
// failure it writes the reset command before it reports done.
// Assumes: start and abort are synchronous pulses, and the bus master handles strobes.
module toggle_poll_ctrl #(
    parameter int          ADDR_W    = 24,
    parameter int          DATA_W    = 8,
    parameter int          MAX_PAIRS = 1024,
    parameter int          TOG_BIT   = 6,
    parameter int          TMO_BIT   = 5,
    parameter logic [7:0]  RESET_CMD = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              pass
);
    import toggle_poll_pkg::*;

    poll_state_t       state;
    logic              rechecking;
    logic [ADDR_W-1:0] addr_q;
    logic              busy, drop, accept;
    logic              want, want_we;
    logic              xfer_done, cap_first, cap_second;
    logic              toggled, timeout_hi, at_limit, bump;
    decision_t         dec;

    // Request decode and handshake qualifiers.
    always_comb begin
        busy       = (state != ST_IDLE) && (state != ST_DONE);
        drop       = busy && abort;
        accept     = !busy && start;
        want       = (state == ST_RD_FIRST) || (state == ST_RD_SECOND) ||
                     (state == ST_CMD_RESET);
        want_we    = (state == ST_CMD_RESET);
        cap_first  = (state == ST_RD_FIRST)  && xfer_done && !abort;
        cap_second = (state == ST_RD_SECOND) && xfer_done && !abort;
        dec        = decide(toggled, timeout_hi, rechecking, at_limit);
        bump       = (state == ST_DECIDE) && !abort &&
                     ((dec == DEC_AGAIN) || (dec == DEC_RECHECK));
    end

    tp_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (want),
        .drop       (drop),
        .want_we    (want_we),
        .want_addr  (addr_q),
        .want_wdata (DATA_W'(RESET_CMD)),
        .bus_ack    (bus_ack),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .xfer_done  (xfer_done)
    );

    tp_sample_cmp #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT), .TMO_BIT(TMO_BIT)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_first  (cap_first),
        .cap_second (cap_second),
        .rdata      (bus_rdata),
        .toggled    (toggled),
        .timeout_hi (timeout_hi)
    );

    tp_pair_count #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .bump     (bump),
        .at_limit (at_limit)
    );

    // Poll sequencing, recheck tracking and result holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rechecking <= 1'b0;
            addr_q     <= '0;
            done       <= 1'b0;
            pass       <= 1'b0;
        end else if (accept) begin
            state      <= ST_RD_FIRST;
            rechecking <= 1'b0;
            addr_q     <= op_addr;
            done       <= 1'b0;
            pass       <= 1'b0;
        end else if (drop) begin
            state      <= ST_IDLE;
            rechecking <= 1'b0;
        end else begin
            unique case (state)
                ST_RD_FIRST:  if (xfer_done) state <= ST_RD_SECOND;
                ST_RD_SECOND: if (xfer_done) state <= ST_DECIDE;
                ST_DECIDE: begin
                    unique case (dec)
                        DEC_PASS: begin
                            state <= ST_DONE;
                            done  <= 1'b1;
                            pass  <= 1'b1;
                        end
                        DEC_RECHECK: begin
                            state      <= ST_RD_FIRST;
                            rechecking <= 1'b1;
                        end
                        DEC_AGAIN: state <= ST_RD_FIRST;
                        default:   state <= ST_CMD_RESET;
                    endcase
                end
                ST_CMD_RESET: if (xfer_done) begin
                    state <= ST_DONE;
                    done  <= 1'b1;
                    pass  <= 1'b0;
                end
                default: state <= state;
            endcase
        end
    end

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));

    // R7
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    // R5
    reset_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !pass) |-> $past(bus_req && bus_ack && bus_we));

    // R2
    pass_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && pass) |-> $past(!bus_req));

    // R8
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy && !start) |=> (!bus_req && !done));

endmodule

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;

    localparam int AW = 24;
    localparam int DW = 8;
    localparam int MAXP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic          bus_req, bus_we, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          done, pass;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    toggle_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_PAIRS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .op_addr(op_addr),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .pass(pass)
    );

    // Device model: acknowledges each request after two cycles, replays a status script.
    logic [7:0]    script [64];
    int            sbase = 0;
    int            rd_cnt = 0, wr_cnt = 0;
    logic [7:0]    wr_data;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] exp_addr = '0;
    int            addr_bad = 0, gap_bad = 0;
    int            wcnt = 0;
    logic          ack_prev = 1'b0;

    initial begin
        bus_ack = 1'b0;
        bus_rdata = '0;
        wr_data = '0;
        wr_addr = '0;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        ack_prev <= bus_req && bus_ack;
        if (ack_prev && bus_req) gap_bad <= gap_bad + 1;
        if (bus_req && bus_ack) begin
            if (bus_we) begin
                wr_cnt  <= wr_cnt + 1;
                wr_data <= bus_wdata;
                wr_addr <= bus_addr;
            end else begin
                rd_cnt <= rd_cnt + 1;
                if (bus_addr != exp_addr) addr_bad <= addr_bad + 1;
            end
        end
        if (bus_ack) begin
            bus_ack <= 1'b0;
        end else if (bus_req) begin
            if (wcnt == 1) begin
                bus_ack   <= 1'b1;
                bus_rdata <= script[(rd_cnt - sbase) & 63];
                wcnt      <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            wcnt <= 0;
        end
    end

    function automatic logic [7:0] st(input bit b6, input bit b5, input bit noise);
        return {1'b0, b6, b5, 2'b00, noise, 2'b01};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(8 * 100000);
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic clear_script();
        for (int i = 0; i < 64; i++) script[i] = st(1'b0, 1'b0, 1'b0);
        sbase = rd_cnt;
    endtask

    task automatic kick(input logic [AW-1:0] a);
        @(negedge clk);
        op_addr = a;
        exp_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_addr = ~a;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk({req, " done reached"}, int'(done), 1);
    endtask

    task automatic t_reset();
        // R9
        chk("R9 bus_req", int'(bus_req), 0);
        chk("R9 done", int'(done), 0);
        chk("R9 pass", int'(pass), 0);
    endtask

    task automatic t_quiet_pass();
        int r0 = rd_cnt, w0 = wr_cnt;
        clear_script();
        script[0] = st(1, 0, 0);
        script[1] = st(1, 0, 1);
        kick(24'h012345);
        chk("R7 done low after start", int'(done), 0);
        wait_done("R2");
        chk("R2 pass", int'(pass), 1);
        chk("R1 read count", rd_cnt - r0, 2);
        chk("R2 no write", wr_cnt - w0, 0);
        chk("R1 read address", addr_bad, 0);
        repeat (20) @(negedge clk);
        chk("R7 done held", int'(done), 1);
        chk("R7 pass held", int'(pass), 1);
    endtask

    task automatic t_poll_again();
        int r0 = rd_cnt, w0 = wr_cnt;
        clear_script();
        script[0] = st(1, 0, 0); script[1] = st(0, 0, 0);
        script[2] = st(1, 0, 1); script[3] = st(0, 0, 0);
        script[4] = st(0, 0, 1); script[5] = st(0, 0, 0);
        kick(24'h00A000);
        wait_done("R3");
        chk("R3 pass", int'(pass), 1);
        chk("R3 reads", rd_cnt - r0, 6);
        chk("R3 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_timeout_recover();
        int r0 = rd_cnt, w0 = wr_cnt;
        clear_script();
        script[0] = st(1, 0, 0); script[1] = st(0, 1, 0);
        script[2] = st(1, 1, 0); script[3] = st(1, 1, 1);
        kick(24'h0000F0);
        wait_done("R4");
        chk("R4 pass", int'(pass), 1);
        chk("R4 reads", rd_cnt - r0, 4);
        chk("R4 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_timeout_fail();
        int r0 = rd_cnt, w0 = wr_cnt;
        clear_script();
        script[0] = st(0, 0, 0); script[1] = st(1, 1, 0);
        script[2] = st(0, 1, 0); script[3] = st(1, 1, 0);
        kick(24'h3C0001);
        wait_done("R5");
        chk("R5 pass low", int'(pass), 0);
        chk("R5 reads", rd_cnt - r0, 4);
        chk("R5 one write", wr_cnt - w0, 1);
        chk("R5 write data", int'(wr_data), 8'hF0);
        chk("R5 write addr", int'(wr_addr), 24'h3C0001);
    endtask

    task automatic t_max_pairs();
        int r0 = rd_cnt, w0 = wr_cnt;
        clear_script();
        for (int i = 0; i < 64; i++) script[i] = st(1'(i % 2), 1'b0, 1'b0);
        kick(24'h000777);
        wait_done("R6");
        chk("R6 pass low", int'(pass), 0);
        chk("R6 reads", rd_cnt - r0, 2 * MAXP);
        chk("R6 one write", wr_cnt - w0, 1);
        chk("R6 write data", int'(wr_data), 8'hF0);
    endtask

    task automatic t_busy_start();
        int r0 = rd_cnt;
        clear_script();
        script[0] = st(1, 0, 0); script[1] = st(0, 0, 0);
        script[2] = st(1, 0, 0); script[3] = st(0, 0, 0);
        script[4] = st(1, 0, 0); script[5] = st(1, 0, 0);
        script[6] = st(1, 0, 0); script[7] = st(0, 0, 0);
        kick(24'h000200);
        repeat (5) @(negedge clk);
        start = 1'b1;
        op_addr = 24'h000300;
        @(negedge clk);
        start = 1'b0;
        wait_done("R7 busy start");
        chk("R7 busy start ignored reads", rd_cnt - r0, 6);
        chk("R7 busy start pass", int'(pass), 1);
        chk("R7 address kept", addr_bad, 0);
    endtask

    task automatic t_abort();
        int r0 = rd_cnt, w0 = wr_cnt, n = 0;
        clear_script();
        script[0] = st(1, 0, 0); script[1] = st(0, 1, 0);
        kick(24'h000050);
        while ((rd_cnt - r0 < 2 || !bus_req) && n < 200) begin
            @(negedge clk);
            n++;
        end
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R8 req dropped", int'(bus_req), 0);
        chk("R8 done low", int'(done), 0);
        repeat (10) @(negedge clk);
        chk("R8 stays idle", int'(bus_req), 0);
        chk("R8 no write", wr_cnt - w0, 0);
        r0 = rd_cnt;
        clear_script();
        script[0] = st(1, 0, 0); script[1] = st(0, 0, 0);
        script[2] = st(1, 0, 0); script[3] = st(1, 0, 0);
        kick(24'h000060);
        wait_done("R8 fresh");
        chk("R8 fresh pass", int'(pass), 1);
        chk("R8 fresh reads", rd_cnt - r0, 4);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) script[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_quiet_pass();
        t_poll_again();
        t_timeout_recover();
        t_timeout_fail();
        t_max_pairs();
        t_busy_start();
        t_abort();
        chk("R1 idle gap", gap_bad, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule